// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the combinational execute stage of a load/store RISC core. Each cycle it takes a 4-bit operation code, a first register operand, and a second operand that an upstream barrel shifter has already prepared. It also takes the shifter's carry-out, the current condition flags and a set-flags control. From these it produces a result word, a write-enable for that result and the next value of the four condition flags.

Sixteen data-processing operations are covered:
- adds and subtracts, with or without carry chaining;
- subtracts with the operands reversed;
- bitwise logic, including bit-clear, move and move-inverted;
- four compare and test forms that only update the flags.

Arithmetic operations take their carry from the adder. For subtracts, the carry is the inverted borrow. Logical operations pass the shifter's carry through and leave overflow alone.

The caller registers the flags. The block never holds state, so a flag that is not updated is simply passed from the flag input to the flag output.

Top module: `flag_alu`

## Requirements
- R1: The opcode is decoded as follows: 0 AND, 1 XOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 OR, 13 MOV, 14 BIC, 15 MVN. The logical results are:
  - AND gives rnVal&op2Val; XOR gives rnVal^op2Val; OR gives rnVal|op2Val;
  - MOV gives op2Val; BIC gives rnVal&~op2Val; MVN gives ~op2Val.
- R2: Uncarried arithmetic: ADD gives rnVal+op2Val, SUB gives rnVal-op2Val, and RSB gives op2Val-rnVal, all modulo 2^32.
- R3: Carry-chained arithmetic uses the current C flag (flagsIn[1]): ADC gives rnVal+op2Val+C, SBC gives rnVal-op2Val-(1-C), and RSC gives op2Val-rnVal-(1-C).
- R4: Opcodes 8 to 11 drive resultWe low. They still present their computed value on result and set flags from it: TST from AND, TEQ from XOR, CMP from SUB and CMN from ADD. All other opcodes drive resultWe high.
- R5: The flags are packed as flagsOut[3]=N, [2]=Z, [1]=C, [0]=V. With setFlags high, N equals result bit 31 and Z is 1 exactly when result is zero.
- R6: For the arithmetic opcodes (2 to 7, 10, 11) with setFlags high, C and V are set as follows:
  - C is the carry out of the 32-bit add; for the subtract forms this means 1 when no borrow occurs.
  - V is 1 when the signed result does not fit in 32 bits. For example, -1+1 gives NZCV=0110 and 0x7FFFFFFF+1 gives NZCV=1001.
- R7: For the logical opcodes (0, 1, 8, 9, 12 to 15) with setFlags high, C equals shiftCarry and V equals flagsIn[0].
- R8: With setFlags low, flagsOut equals flagsIn for every opcode, while result and resultWe behave as in R1 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | Data-processing operation code |
| rnVal | input | 32 | First operand |
| op2Val | input | 32 | Second operand, already shifted |
| shiftCarry | input | 1 | Carry-out of the shifter, used by logical operations |
| flagsIn | input | 4 | Current N, Z, C, V flags |
| setFlags | input | 1 | Allows the flags to update |
| result | output | 32 | Computed value |
| resultWe | output | 1 | Result should be written back |
| flagsOut | output | 4 | Next N, Z, C, V flags |

## Verification
The assertions check these properties on every input change:
- compare and test forms never raise the write-enable;
- N and Z agree with the result whenever flags are set;
- logical operations take C from the shifter and keep V;
- the flags pass through untouched when set-flags is low.

Only the bench scenarios can show that each opcode computes the right value and that carry and overflow are right at their boundaries. These scenarios include signed wrap, inverted borrow, carry chaining through SBC and RSC, and a sweep of operands against a wide-integer reference.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND      = 4'd0,
    OP_XOR      = 4'd1,
    OP_SUB      = 4'd2,
    OP_RSUB     = 4'd3,
    OP_ADD      = 4'd4,
    OP_ADDC     = 4'd5,
    OP_SUBC     = 4'd6,
    OP_RSUBC    = 4'd7,
    OP_TESTAND  = 4'd8,
    OP_TESTXOR  = 4'd9,
    OP_CMPSUB   = 4'd10,
    OP_CMPADD   = 4'd11,
    OP_OR       = 4'd12,
    OP_MOVE     = 4'd13,
    OP_CLRBITS  = 4'd14,
    OP_MOVEINV  = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } carrySel_e;

  typedef enum logic [2:0] {
    LG_AND    = 3'd0,
    LG_XOR    = 3'd1,
    LG_OR     = 3'd2,
    LG_PASS   = 3'd3,
    LG_CLEAR  = 3'd4,
    LG_INVERT = 3'd5
  } logicSel_e;

  typedef struct packed {
    logic      isArith;
    logic      invRn;
    logic      invOp2;
    carrySel_e cinSel;
    logicSel_e logicSel;
    logic      writeBack;
  } aluCtrl_t;

  localparam int FLAG_W = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic [3:0] opcode,
  output aluCtrl_t   ctrl
);

  aluOp_e opSel;
  assign opSel = aluOp_e'(opcode);

  always_comb begin
    ctrl = '{isArith: 1'b0, invRn: 1'b0, invOp2: 1'b0, cinSel: CIN_ZERO,
             logicSel: LG_AND, writeBack: 1'b1};
    unique case (opSel)
      OP_AND:     ctrl.logicSel = LG_AND;
      OP_XOR:     ctrl.logicSel = LG_XOR;
      OP_OR:      ctrl.logicSel = LG_OR;
      OP_MOVE:    ctrl.logicSel = LG_PASS;
      OP_CLRBITS: ctrl.logicSel = LG_CLEAR;
      OP_MOVEINV: ctrl.logicSel = LG_INVERT;
      OP_TESTAND: begin ctrl.logicSel = LG_AND; ctrl.writeBack = 1'b0; end
      OP_TESTXOR: begin ctrl.logicSel = LG_XOR; ctrl.writeBack = 1'b0; end
      OP_ADD:     ctrl.isArith = 1'b1;
      OP_ADDC:    begin ctrl.isArith = 1'b1; ctrl.cinSel = CIN_FLAG; end
      OP_SUB:     begin ctrl.isArith = 1'b1; ctrl.invOp2 = 1'b1; ctrl.cinSel = CIN_ONE; end
      OP_SUBC:    begin ctrl.isArith = 1'b1; ctrl.invOp2 = 1'b1; ctrl.cinSel = CIN_FLAG; end
      OP_RSUB:    begin ctrl.isArith = 1'b1; ctrl.invRn = 1'b1; ctrl.cinSel = CIN_ONE; end
      OP_RSUBC:   begin ctrl.isArith = 1'b1; ctrl.invRn = 1'b1; ctrl.cinSel = CIN_FLAG; end
      OP_CMPSUB:  begin ctrl.isArith = 1'b1; ctrl.invOp2 = 1'b1; ctrl.cinSel = CIN_ONE;
                        ctrl.writeBack = 1'b0; end
      OP_CMPADD:  begin ctrl.isArith = 1'b1; ctrl.writeBack = 1'b0; end
      default:    ctrl.writeBack = 1'b1;
    endcase
  end

  always_comb begin
    if (!$isunknown(opcode)) begin
      // R4
      cmp_no_write_chk: assert ((opcode[3:2] == 2'b10) == !ctrl.writeBack)
        else $error("compare/test write-enable mismatch for opcode %0d", opcode);
    end
  end

endmodule

// File: rtl/flag_alu_adder.sv
module flag_alu_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              carryOut,
  output logic              overflow
);

  localparam int SUM_W = DATA_W + 1;
  localparam int MSB   = DATA_W - 1;

  logic [SUM_W-1:0] wideSum;

  assign wideSum  = {1'b0, aIn} + {1'b0, bIn} + {{DATA_W{1'b0}}, cin};
  assign sum      = wideSum[MSB:0];
  assign carryOut = wideSum[DATA_W];
  assign overflow = (aIn[MSB] == bIn[MSB]) && (sum[MSB] != aIn[MSB]);

endmodule

// File: rtl/flag_alu_datapath.sv
module flag_alu_datapath
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] rnVal,
  input  logic [DATA_W-1:0] op2Val,
  input  logic              shiftCarry,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic              setFlags,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsOut
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addA, addB, addSum, logicRes;
  logic              addCin, addCarry, addOvf;
  logic [FLAG_W-1:0] newFlags;

  assign addA = ctrl.invRn  ? ~rnVal  : rnVal;
  assign addB = ctrl.invOp2 ? ~op2Val : op2Val;

  always_comb begin
    unique case (ctrl.cinSel)
      CIN_ONE:  addCin = 1'b1;
      CIN_FLAG: addCin = flagsIn[FLAG_C];
      default:  addCin = 1'b0;
    endcase
  end

  flag_alu_adder #(.DATA_W(DATA_W)) u_adder (
    .aIn      (addA),
    .bIn      (addB),
    .cin      (addCin),
    .sum      (addSum),
    .carryOut (addCarry),
    .overflow (addOvf)
  );

  always_comb begin
    unique case (ctrl.logicSel)
      LG_XOR:    logicRes = rnVal ^ op2Val;
      LG_OR:     logicRes = rnVal | op2Val;
      LG_PASS:   logicRes = op2Val;
      LG_CLEAR:  logicRes = rnVal & ~op2Val;
      LG_INVERT: logicRes = ~op2Val;
      default:   logicRes = rnVal & op2Val;
    endcase
  end

  assign result = ctrl.isArith ? addSum : logicRes;

  always_comb begin
    newFlags[FLAG_N] = result[MSB];
    newFlags[FLAG_Z] = ~|result;
    newFlags[FLAG_C] = ctrl.isArith ? addCarry : shiftCarry;
    newFlags[FLAG_V] = ctrl.isArith ? addOvf   : flagsIn[FLAG_V];
  end

  assign flagsOut = setFlags ? newFlags : flagsIn;

  always_comb begin
    if (!$isunknown({ctrl, rnVal, op2Val, shiftCarry, flagsIn, setFlags})) begin
      // R8
      flags_hold_chk: assert (setFlags || flagsOut == flagsIn)
        else $error("flags changed while setFlags low");
      // R5
      zero_flag_chk: assert (!setFlags || (flagsOut[FLAG_Z] == (result == '0)))
        else $error("Z flag disagrees with result");
      // R5
      neg_flag_chk: assert (!setFlags || (flagsOut[FLAG_N] == result[MSB]))
        else $error("N flag disagrees with result");
      // R7
      logic_carry_chk: assert (!setFlags || ctrl.isArith ||
                               (flagsOut[FLAG_C] == shiftCarry && flagsOut[FLAG_V] == flagsIn[FLAG_V]))
        else $error("logical op did not take shifter carry or keep V");
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] rnVal,
  input  logic [DATA_W-1:0] op2Val,
  input  logic              shiftCarry,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic              setFlags,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [FLAG_W-1:0] flagsOut
);

  aluCtrl_t ctrl;

  flag_alu_ctrl u_ctrl (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  flag_alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctrl       (ctrl),
    .rnVal      (rnVal),
    .op2Val     (op2Val),
    .shiftCarry (shiftCarry),
    .flagsIn    (flagsIn),
    .setFlags   (setFlags),
    .result     (result),
    .flagsOut   (flagsOut)
  );

  assign resultWe = ctrl.writeBack;

endmodule

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode;
  logic [31:0] rnVal, op2Val, result;
  logic        shiftCarry, setFlags, resultWe;
  logic [3:0]  flagsIn, flagsOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flag_alu u_dut (
    .opcode(opcode), .rnVal(rnVal), .op2Val(op2Val), .shiftCarry(shiftCarry),
    .flagsIn(flagsIn), .setFlags(setFlags), .result(result), .resultWe(resultWe),
    .flagsOut(flagsOut)
  );

  // fields: op[109:106] rn[105:74] op2[73:42] fin[41:38] sc[37] res[36:5] we[4] nzcv[3:0]
  localparam int NV = 17;
  localparam logic [109:0] VEC [NV] = '{
    {4'd4,  32'hFFFFFFFF, 32'h00000001, 4'b0000, 1'b0, 32'h00000000, 1'b1, 4'b0110}, // R2 R6 -1+1
    {4'd4,  32'h7FFFFFFF, 32'h00000001, 4'b0000, 1'b0, 32'h80000000, 1'b1, 4'b1001}, // R6 signed wrap
    {4'd2,  32'h00000005, 32'h00000007, 4'b0000, 1'b0, 32'hFFFFFFFE, 1'b1, 4'b1000}, // R2 borrow
    {4'd3,  32'h00000005, 32'h00000007, 4'b0000, 1'b0, 32'h00000002, 1'b1, 4'b0010}, // R2 reverse
    {4'd6,  32'h0000000A, 32'h00000003, 4'b0000, 1'b0, 32'h00000006, 1'b1, 4'b0010}, // R3 SBC C=0
    {4'd7,  32'h00000003, 32'h0000000A, 4'b0010, 1'b0, 32'h00000007, 1'b1, 4'b0010}, // R3 RSC C=1
    {4'd5,  32'hFFFFFFFF, 32'h00000000, 4'b0010, 1'b0, 32'h00000000, 1'b1, 4'b0110}, // R3 ADC
    {4'd10, 32'h80000000, 32'h00000001, 4'b0000, 1'b0, 32'h7FFFFFFF, 1'b0, 4'b0011}, // R4 CMP
    {4'd8,  32'h000000F0, 32'h0000000F, 4'b0001, 1'b1, 32'h00000000, 1'b0, 4'b0111}, // R4 R7 TST
    {4'd9,  32'hFFFFFFFF, 32'h0000FFFF, 4'b0000, 1'b0, 32'hFFFF0000, 1'b0, 4'b1000}, // R4 TEQ
    {4'd11, 32'h00000001, 32'hFFFFFFFF, 4'b0000, 1'b0, 32'h00000000, 1'b0, 4'b0110}, // R4 CMN
    {4'd14, 32'h000000FF, 32'h0000000F, 4'b1111, 1'b0, 32'h000000F0, 1'b1, 4'b0001}, // R1 R7 BIC
    {4'd15, 32'h00000123, 32'h00000000, 4'b0000, 1'b1, 32'hFFFFFFFF, 1'b1, 4'b1010}, // R1 MVN
    {4'd12, 32'h00000F00, 32'h000000F0, 4'b0000, 1'b0, 32'h00000FF0, 1'b1, 4'b0000}, // R1 OR
    {4'd1,  32'hAAAAAAAA, 32'hFFFFFFFF, 4'b0000, 1'b1, 32'h55555555, 1'b1, 4'b0010}, // R1 XOR
    {4'd13, 32'h00000123, 32'h00000000, 4'b0000, 1'b0, 32'h00000000, 1'b1, 4'b0100}, // R1 R5 MOV
    {4'd0,  32'hFF00FF00, 32'h0FF00FF0, 4'b0001, 1'b0, 32'h0F000F00, 1'b1, 4'b0001}  // R1 AND
  };
  localparam int VREQ [NV] = '{6, 6, 2, 2, 3, 3, 3, 4, 4, 4, 4, 1, 1, 1, 1, 1, 1};

  task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got res=%h we=%b nzcv=%b, expected res=%h we=%b nzcv=%b",
               tag, got[36:5], got[4], got[3:0], exp[36:5], exp[4], exp[3:0]);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] fin, input logic sc, input logic sf);
    @(negedge clk);
    opcode = op; rnVal = a; op2Val = b; flagsIn = fin; shiftCarry = sc; setFlags = sf;
    #1;
  endtask

  // reference built on 64-bit integer arithmetic
  task automatic refModel(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [3:0] fin, input logic sc, input logic sf,
                          output logic [36:0] exp);
    longint sa, sb, ua, ub, cIn, sExact, uExact;
    logic [31:0] r;
    logic c, v, we, arith;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
    cIn = longint'(fin[1]);
    arith = 1'b1; sExact = 0; uExact = 0; r = '0;
    case (op)
      4'd4, 4'd11: begin sExact = sa + sb;           uExact = ua + ub; end
      4'd5:        begin sExact = sa + sb + cIn;     uExact = ua + ub + cIn; end
      4'd2, 4'd10: begin sExact = sa - sb;           uExact = ua - ub; end
      4'd6:        begin sExact = sa - sb - (1-cIn); uExact = ua - ub - (1-cIn); end
      4'd3:        begin sExact = sb - sa;           uExact = ub - ua; end
      4'd7:        begin sExact = sb - sa - (1-cIn); uExact = ub - ua - (1-cIn); end
      default: arith = 1'b0;
    endcase
    case (op)
      4'd0, 4'd8: r = a & b;
      4'd1, 4'd9: r = a ^ b;
      4'd12:      r = a | b;
      4'd13:      r = b;
      4'd14:      r = a & ~b;
      4'd15:      r = ~b;
      default:    r = sExact[31:0];
    endcase
    if (arith) begin
      v = (sExact > 64'sd2147483647) || (sExact < -64'sd2147483648);
      if (op == 4'd4 || op == 4'd5 || op == 4'd11) c = (uExact > 64'sd4294967295);
      else c = (uExact >= 0);
    end else begin
      c = sc; v = fin[0];
    end
    we = !(op >= 4'd8 && op <= 4'd11);
    exp = {r, we, sf ? {r[31], (r == 32'd0), c, v} : fin};
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [36:0] exp;
    logic [31:0] seed;
    opcode = 4'd13; rnVal = '0; op2Val = '0; flagsIn = 4'b0000; shiftCarry = 1'b0; setFlags = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // idle state: MOV of zero, flags held (R8, R1)
    apply(4'd13, 32'h0, 32'h0, 4'b0000, 1'b0, 1'b0);
    check("R8 idle", {result, resultWe, flagsOut}, {32'h0, 1'b1, 4'b0000});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][109:106], VEC[i][105:74], VEC[i][73:42], VEC[i][41:38], VEC[i][37], 1'b1);
      check($sformatf("R%0d vec%0d", VREQ[i], i), {result, resultWe, flagsOut}, VEC[i][36:0]);
    end

    // R8: overflowing add with setFlags low keeps the flags
    apply(4'd4, 32'h7FFFFFFF, 32'h1, 4'b1010, 1'b0, 1'b0);
    check("R8 hold add", {result, resultWe, flagsOut}, {32'h80000000, 1'b1, 4'b1010});
    // R8: compare with setFlags low changes nothing visible
    apply(4'd10, 32'h1, 32'h1, 4'b0101, 1'b1, 1'b0);
    check("R8 hold cmp", {resultWe, flagsOut}, {32'h0, 1'b0, 4'b0101});
    // R3 R6: SBC of equal values with C=0 borrows through zero
    apply(4'd6, 32'h5, 32'h5, 4'b0000, 1'b0, 1'b1);
    check("R3 sbc borrow", {result, resultWe, flagsOut}, {32'hFFFFFFFF, 1'b1, 4'b1000});
    // R6 R2: SUB of 0x80000000 - 1 overflows into positive
    apply(4'd2, 32'h80000000, 32'h1, 4'b0000, 1'b0, 1'b1);
    check("R6 sub ovf", {result, resultWe, flagsOut}, {32'h7FFFFFFF, 1'b1, 4'b0011});

    // sweep against the wide-integer reference (R1 to R8)
    seed = 32'h1234_5678;
    for (int k = 0; k < 400; k++) begin
      logic [3:0]  op;
      logic [31:0] a, b;
      logic [3:0]  fin;
      seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; b = (k % 8 == 0) ? ~a : seed;
      op  = 4'(k % 16);
      fin = seed[7:4];
      apply(op, a, b, fin, seed[9], seed[11] | (k % 3 != 0));
      refModel(op, a, b, fin, seed[9], seed[11] | (k % 3 != 0), exp);
      check($sformatf("R%0d sweep op%0d", (op >= 4'd8 && op <= 4'd11) ? 4 :
                      ((op >= 4'd2 && op <= 4'd7) ? 6 : 7), op),
            {result, resultWe, flagsOut}, exp);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule